// File: doc/BRIEF.md
# Status-Change History Recorder

This block keeps a running log of status transitions. It watches four 4-bit status channels: the emulated front-end chip, the external status module, and the merged status sent to the central trigger controller and to the local trigger controller. Whenever any of these channels takes a new value, the block writes one 64-bit record. Each record holds the machine time at that moment and a snapshot of all four status codes. The time is an orbit count and a bunch-crossing count, both generated inside the block from a bunch-crossing-zero strobe. The record also carries four auxiliary flag bits: run start/stop and which trigger controller is selected.

Records go into a circular memory of `2**ADDR_W` entries, 4096 by default. When the memory is full, new records overwrite the oldest. Software reads back the history through a valid/ready read port. It also sees the current write pointer and a sticky wrap flag. When the wrap flag is set, the entry at the write pointer is the oldest one. When it is clear, the oldest entry is entry 0.

The read port takes requests on a valid/ready pair. A request is accepted on a clock edge where `rd_req_valid_i` and `rd_req_ready_o` are both high. The response appears one cycle later on `rd_rsp_valid_o`/`rd_data_o`. While the consumer holds `rd_rsp_ready_i` low, the response stays frozen and `rd_req_ready_o` stays low, so no request is lost or overtaken. A read of the entry being written in the same cycle returns the old contents.

Top module: `hist_recorder`

## Requirements
- R1: The bunch-crossing counter (12 bits) increments every cycle and wraps modulo 4096. A cycle with `bx0_i` high makes it 0 on the next cycle and increments the 32-bit orbit counter. Both counters are 0 after reset.
- R2: A record is written at the clock edge ending any cycle in which the concatenation {chip, local, module, central} differs from its value in the previous cycle. The reference right after reset is all zeros. Each write advances `wr_ptr_o` by one.
- R3: A cycle in which several status fields change at once writes exactly one record.
- R4: A change of `rsv_i` alone writes no record and leaves `wr_ptr_o` unchanged.
- R5: The record layout from the MSB down is:
  - orbit [63:32]
  - bunch crossing [31:20]
  - chip [19:16]
  - local [15:12]
  - module [11:8]
  - central [7:4]
  - reserved flags [3:0]
- R6: The stored time and reserved flags are the counter values and `rsv_i` present in the same cycle as the new status.
- R7: After the entry at address `2**ADDR_W-1` is written, the pointer returns to 0 and `wrapped_o` becomes 1. The flag stays 1 until reset.
- R8: `rd_req_ready_o` equals `!rd_rsp_valid_o || rd_rsp_ready_i`. An accepted request yields `rd_rsp_valid_o` = 1 with the addressed record on the next cycle. While `rd_rsp_valid_o` is high and `rd_rsp_ready_i` is low, the valid signal and the data stay unchanged.
- R9: During and after reset, `wr_ptr_o` is 0, `wrapped_o` is 0, `rd_rsp_valid_o` is 0 and `rd_req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx0_i | input | 1 | Bunch-crossing-zero strobe |
| st_chip_i | input | 4 | Emulated chip status |
| st_loc_i | input | 4 | Status sent to local trigger controller |
| st_mod_i | input | 4 | External status-module status |
| st_cen_i | input | 4 | Status sent to central trigger controller |
| rsv_i | input | 4 | Run start/stop and controller-select flags, stored only |
| wr_ptr_o | output | ADDR_W | Next entry to be written |
| wrapped_o | output | 1 | Sticky: memory has wrapped at least once |
| rd_req_valid_i | input | 1 | Read request valid |
| rd_req_ready_o | output | 1 | Read request can be accepted |
| rd_addr_i | input | ADDR_W | Entry to read |
| rd_rsp_valid_o | output | 1 | Read data valid |
| rd_rsp_ready_i | input | 1 | Consumer takes read data |
| rd_data_o | output | 64 | Record read |

## Verification
Faults show up in different places depending on where they sit:
- A broken change detector shows up at once as `wr_ptr_o` failing to step, or stepping on a reserved-only or multi-field change.
- A faulty time base only shows up later, when a record is read back with a wrong orbit or crossing value.
- Field packing errors also appear only on readback, as swapped nibbles.
- A pointer or wrap fault reveals itself when the memory turns over: `wrapped_o` sets too early or too late, or older entries are found overwritten out of order.
- Read-port handshake faults appear within one cycle as data that moves or vanishes under back-pressure.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int ST_W  = 4;
  localparam int BX_W  = 12;
  localparam int ORB_W = 32;
  localparam int RSV_W = 4;
  localparam int REC_W = ORB_W + BX_W + 4 * ST_W + RSV_W;

  typedef struct packed {
    logic [ST_W-1:0] chip;
    logic [ST_W-1:0] loc;
    logic [ST_W-1:0] modl;
    logic [ST_W-1:0] cen;
  } status_t;

  typedef struct packed {
    logic [ORB_W-1:0] orbit;
    logic [BX_W-1:0]  bx;
    status_t          st;
    logic [RSV_W-1:0] rsv;
  } record_t;
endpackage

// File: rtl/hist_timebase.sv
module hist_timebase #(
  parameter int ORB_W = 32,
  parameter int BX_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bx0_i,
  output logic [ORB_W-1:0] orbit_o,
  output logic [BX_W-1:0]  bx_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      orbit_o <= '0;
      bx_o    <= '0;
    end else if (bx0_i) begin
      orbit_o <= orbit_o + 1'b1;
      bx_o    <= '0;
    end else begin
      bx_o    <= bx_o + 1'b1;
    end
  end
endmodule

// File: rtl/hist_change_det.sv
module hist_change_det
  import hist_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  status_t st_i,
  output logic    change_o
);
  status_t ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= st_i;
  end

  always_comb change_o = rst_n && (st_i != ref_q);
endmodule

// File: rtl/hist_ring.sv
module hist_ring #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              wrapped_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              accept;

  always_comb begin
    req_ready_o = !rsp_valid_o || rsp_ready_i;
    accept      = req_valid_i && req_ready_o;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_ptr_o] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_o  <= '0;
      wrapped_o <= 1'b0;
    end else if (wr_en_i) begin
      wr_ptr_o <= wr_ptr_o + 1'b1;
      if (wr_ptr_o == LAST) wrapped_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= mem[req_addr_i];
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hist_recorder.sv
module hist_recorder
  import hist_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx0_i,
  input  logic [3:0]        st_chip_i,
  input  logic [3:0]        st_loc_i,
  input  logic [3:0]        st_mod_i,
  input  logic [3:0]        st_cen_i,
  input  logic [3:0]        rsv_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              wrapped_o,
  input  logic              rd_req_valid_i,
  output logic              rd_req_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_rsp_valid_o,
  input  logic              rd_rsp_ready_i,
  output logic [63:0]       rd_data_o
);
  logic [ORB_W-1:0] orbit;
  logic [BX_W-1:0]  bx;
  status_t          st;
  record_t          rec;
  logic             change;

  always_comb begin
    st.chip   = st_chip_i;
    st.loc    = st_loc_i;
    st.modl   = st_mod_i;
    st.cen    = st_cen_i;
    rec.orbit = orbit;
    rec.bx    = bx;
    rec.st    = st;
    rec.rsv   = rsv_i;
  end

  hist_timebase #(.ORB_W(ORB_W), .BX_W(BX_W)) u_time (
    .clk(clk), .rst_n(rst_n), .bx0_i(bx0_i), .orbit_o(orbit), .bx_o(bx)
  );

  hist_change_det u_det (
    .clk(clk), .rst_n(rst_n), .st_i(st), .change_o(change)
  );

  hist_ring #(.ADDR_W(ADDR_W), .DATA_W(REC_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(change), .wr_data_i(rec),
    .wr_ptr_o(wr_ptr_o), .wrapped_o(wrapped_o),
    .req_valid_i(rd_req_valid_i), .req_ready_o(rd_req_ready_o),
    .req_addr_i(rd_addr_i),
    .rsp_valid_o(rd_rsp_valid_o), .rsp_ready_i(rd_rsp_ready_i),
    .rsp_data_o(rd_data_o)
  );
endmodule

// File: rtl/hist_recorder_chk.sv
module hist_recorder_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bx0_i,
  input logic [15:0]       st_all,
  input logic [ADDR_W-1:0] wr_ptr_o,
  input logic              wrapped_o,
  input logic              rd_req_ready_o,
  input logic              rd_rsp_valid_o,
  input logic              rd_rsp_ready_i,
  input logic [63:0]       rd_data_o,
  input logic [11:0]       bx,
  input logic [31:0]       orbit
);
  logic [15:0] seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= st_all;
  end

  // R1
  bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bx0_i |=> (bx == $past(bx) + 12'd1) && (orbit == $past(orbit)));
  // R1
  bx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bx0_i |=> (bx == 12'd0) && (orbit == $past(orbit) + 32'd1));
  // R2
  rec_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_all != seen_q) |=> (wr_ptr_o == $past(wr_ptr_o) + 1'b1));
  // R4
  no_rec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_all == seen_q) |=> $stable(wr_ptr_o));
  // R7
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped_o |=> wrapped_o);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_o && !rd_rsp_ready_i) |=> (rd_rsp_valid_o && $stable(rd_data_o)));
  // R8
  always_comb begin
    if (rst_n) begin
      req_ready_chk: assert (rd_req_ready_o == (!rd_rsp_valid_o || rd_rsp_ready_i));
    end
  end
endmodule

bind hist_recorder hist_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bx0_i(bx0_i),
  .st_all({st_chip_i, st_loc_i, st_mod_i, st_cen_i}),
  .wr_ptr_o(wr_ptr_o), .wrapped_o(wrapped_o),
  .rd_req_ready_o(rd_req_ready_o), .rd_rsp_valid_o(rd_rsp_valid_o),
  .rd_rsp_ready_i(rd_rsp_ready_i), .rd_data_o(rd_data_o),
  .bx(bx), .orbit(orbit)
);

// File: tb/tb_hist_recorder.sv
module tb_hist_recorder;
  localparam int PERIOD = 10;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bx0 = 1'b0;
  logic [3:0]    s_chip = '0, s_loc = '0, s_mod = '0, s_cen = '0, rsv = '0;
  logic [AW-1:0] wr_ptr;
  logic          wrapped;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [63:0]   rd_data;

  int checks = 0;
  int fails  = 0;

  logic [63:0]   exp_mem [DEPTH];
  logic [AW-1:0] m_ptr;
  logic          m_wrap;
  logic [15:0]   m_prev;
  logic [11:0]   m_bx;
  logic [31:0]   m_orb;

  always #(PERIOD/2) clk = ~clk;

  hist_recorder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bx0_i(bx0),
    .st_chip_i(s_chip), .st_loc_i(s_loc), .st_mod_i(s_mod), .st_cen_i(s_cen),
    .rsv_i(rsv), .wr_ptr_o(wr_ptr), .wrapped_o(wrapped),
    .rd_req_valid_i(req_valid), .rd_req_ready_o(req_ready), .rd_addr_i(rd_addr),
    .rd_rsp_valid_o(rsp_valid), .rd_rsp_ready_i(rsp_ready), .rd_data_o(rd_data)
  );

  function automatic logic [63:0] pack_rec(input logic [31:0] o, input logic [11:0] b,
                                           input logic [15:0] s, input logic [3:0] r);
    return {o, b, s, r};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ptr = '0; m_wrap = 1'b0; m_prev = '0; m_bx = '0; m_orb = '0;
  endtask

  // Advance one clock; the model consumes the inputs present before the edge.
  task automatic cyc();
    logic [15:0] cur;
    cur = {s_chip, s_loc, s_mod, s_cen};
    if (rst_n) begin
      if (cur != m_prev) begin
        exp_mem[m_ptr] = pack_rec(m_orb, m_bx, cur, rsv);
        if (m_ptr == AW'(DEPTH - 1)) m_wrap = 1'b1;
        m_ptr = m_ptr + 1'b1;
      end
      m_prev = cur;
      if (bx0) begin m_bx = '0; m_orb = m_orb + 1; end
      else m_bx = m_bx + 1'b1;
    end else begin
      model_clear();
    end
    @(negedge clk);
  endtask

  task automatic check_ptr(input string req);
    chk(wr_ptr == m_ptr, req, "wr_ptr", 64'(wr_ptr), 64'(m_ptr));
    chk(wrapped == m_wrap, req, "wrapped", 64'(wrapped), 64'(m_wrap));
  endtask

  task automatic rd_check(input int a, input string req);
    rsp_ready = 1'b1;
    rd_addr = AW'(a);
    req_valid = 1'b1;
    cyc();
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R8", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rd_data === exp_mem[a], req, $sformatf("entry %0d", a), rd_data, exp_mem[a]);
    cyc();
  endtask

  task automatic set_st(input logic [15:0] v);
    {s_chip, s_loc, s_mod, s_cen} = v;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    @(negedge clk);
    cyc(); cyc();
    // R9 reset state
    chk(wr_ptr == '0 && wrapped == 1'b0, "R9", "ptr/wrap in reset", {wr_ptr, 3'b0, wrapped}, 0);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "read port in reset",
        {rsp_valid, req_ready}, 64'b01);
    rst_n = 1'b1;
    cyc(); cyc(); cyc();
    check_ptr("R2");

    // R2: single field change from zero reference
    rsv = 4'ha;
    s_chip = 4'h3;
    cyc();
    check_ptr("R2");
    // R4: reserved-only change leaves pointer unchanged
    rsv = 4'h5;
    cyc(); cyc();
    check_ptr("R4");
    // R3: all four fields change together -> one record
    set_st(16'h9c71);
    cyc();
    check_ptr("R3");
    cyc();
    // R1: bx0 strobe clears the crossing count and bumps the orbit
    bx0 = 1'b1;
    cyc();
    bx0 = 1'b0;
    cyc(); cyc();
    s_cen = 4'h8;   // recorded with bx = 2, orbit = 1
    cyc();
    check_ptr("R1");
    for (int i = 0; i < 3; i++) rd_check(i, "R5");
    chk(exp_mem[2][31:20] == 12'd2 && exp_mem[2][63:32] == 32'd1, "R1",
        "model timestamp", exp_mem[2], 0);
    chk(exp_mem[1][19:4] == 16'h9c71 && exp_mem[1][3:0] == 4'h5, "R6",
        "model fields", exp_mem[1], 0);

    // Random phase: wraps the memory several times
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 4) begin
        case ($urandom % 4)
          0: s_chip = 4'($urandom);
          1: s_loc  = 4'($urandom);
          2: s_mod  = 4'($urandom);
          default: s_cen = 4'($urandom);
        endcase
      end else if (r == 4) begin
        set_st(16'($urandom));
      end else if (r == 5) begin
        rsv = 4'($urandom);
      end
      bx0 = (($urandom % 23) == 0);
      cyc();
      if ((n % 50) == 0) check_ptr("R2");
    end
    bx0 = 1'b0;
    cyc();
    check_ptr("R7");
    for (int i = 0; i < DEPTH; i++) rd_check(i, "R6");

    // R8: back-pressure holds the response
    rsp_ready = 1'b0;
    rd_addr = AW'(5);
    req_valid = 1'b1;
    cyc();
    req_valid = 1'b0;
    chk(rsp_valid && rd_data === exp_mem[5], "R8", "held rsp", rd_data, exp_mem[5]);
    chk(req_ready == 1'b0, "R8", "ready low while stalled", 64'(req_ready), 0);
    rd_addr = AW'(6);
    cyc(); cyc();
    chk(rsp_valid && rd_data === exp_mem[5], "R8", "still held", rd_data, exp_mem[5]);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R8", "ready follows consumer", 64'(req_ready), 1);
    cyc();
    chk(rsp_valid == 1'b0, "R8", "rsp drained", 64'(rsp_valid), 0);

    // R9: reset in mid-run
    rst_n = 1'b0;
    cyc(); cyc();
    chk(wr_ptr == '0 && wrapped == 1'b0 && rsp_valid == 1'b0, "R9", "mid-run reset",
        {wr_ptr, 2'b0, wrapped, rsp_valid}, 0);
    rst_n = 1'b1;
    cyc();
    check_ptr("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule